// File: doc/BRIEF.md
# Bidirectional Row Scan Shifter

This block is the row (common) side of a passive-matrix display driver. A long shift register moves a scan token one row at a time on every falling edge of the line strobe. The token can travel toward higher rows or toward lower rows. The register runs either as one chain across all rows or as two independent half-length chains. In the split form the second half-chain is fed from its own dual-mode serial input. Each register bit, combined with the frame-inversion input and the display enable, is turned into a 2-bit drive-level code for the analog output stage.

The two end pins of the chain swap roles with the direction. The end that leads in the current direction takes serial data in, and the far end carries the last row out to the next cascaded device. Each end pin is modelled as a separate input, output and output-enable. The strobe is sampled in the system clock domain, and a falling edge is detected one register stage after it arrives.

Top module: `row_scan_driver`

## Requirements
- R1: The register changes only in the clock cycle after the strobe `lp` is seen to go from 1 to 0. A rising edge of the strobe, or a strobe held steady at either level, leaves every row unchanged.
- R2: With `scan_up`=1 and `dual_mode`=0, each strobe fall loads `end_a_in` into row 0 and moves row i to row i+1.
- R3: With `scan_up`=0 and `dual_mode`=0, each strobe fall loads `end_b_in` into row ROWS-1 and moves row i+1 to row i.
- R4: With `scan_up`=1 and `dual_mode`=1, `end_a_in` enters row 0 and rows 0..ROWS/2-1 shift upward. `dual_in` enters row ROWS/2 and rows ROWS/2..ROWS-1 shift upward. No bit crosses from row ROWS/2-1 to row ROWS/2.
- R5: With `scan_up`=0 and `dual_mode`=1, `end_b_in` enters row ROWS-1 and the upper half shifts downward. `dual_in` enters row ROWS/2-1 and the lower half shifts downward. No bit crosses from row ROWS/2 to row ROWS/2-1.
- R6: The serial output comes from the far end of the full span in both modes. When `scan_up`=1, `end_b_out` equals row ROWS-1 and only `end_b_oe` is 1. When `scan_up`=0, `end_a_out` equals row 0 and only `end_a_oe` is 1.
- R7: With `disp_on`=1, each row code at `row_lvl[2i+1:2i]` is set by the frame bit F and the row bit R:
  - F=0, R=0 gives 2 (V43).
  - F=0, R=1 gives 0 (V0).
  - F=1, R=0 gives 1 (V12).
  - F=1, R=1 gives 3 (V5).
- R8: While `disp_on`=0, every row code is 3 (V5) and the register is cleared. Strobe falls shift nothing in.
- R9: After `disp_on` returns to 1, every row shows the deselect code (2 with F=0, 1 with F=1) until the next strobe fall shifts in new data.
- R10: The end pin that acts as an output in the current direction has its input ignored. So does `dual_in` in single mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp | input | 1 | Line strobe; falling edge shifts the register |
| scan_up | input | 1 | 1: data moves toward higher rows; 0: toward lower rows |
| dual_mode | input | 1 | 0: one full chain; 1: two half chains |
| disp_on | input | 1 | 0 blanks all rows to V5 and clears the register |
| frame_inv | input | 1 | Frame inversion bit F |
| dual_in | input | 1 | Serial input of the second half chain in dual mode |
| end_a_in | input | 1 | Row-0 end pin, input side |
| end_a_out | output | 1 | Row-0 end pin, output side |
| end_a_oe | output | 1 | Row-0 end pin drives when 1 |
| end_b_in | input | 1 | Last-row end pin, input side |
| end_b_out | output | 1 | Last-row end pin, output side |
| end_b_oe | output | 1 | Last-row end pin drives when 1 |
| row_lvl | output | 2*ROWS | Per-row level code: 0=V0, 1=V12, 2=V43, 3=V5 |

## Verification
On every cycle, the assertions check these behaviours:
- the register holds without a strobe fall;
- the correct serial input lands in the entry row for each direction and mode;
- the half chains stay separate in dual mode;
- a blanked display clears the register and forces V5;
- exactly one end pin drives.

Some behaviours can only be shown by the bench's scenarios:
- full token walks in both directions;
- the four-way level encoding under both frame phases;
- the deselect window after the display is re-enabled;
- the ignored inputs of the unused end pin and of the dual input.

// File: rtl/row_scan_pkg.sv
package row_scan_pkg;
   typedef enum logic [1:0] {
      LVL_V0  = 2'd0,
      LVL_V12 = 2'd1,
      LVL_V43 = 2'd2,
      LVL_V5  = 2'd3
   } drive_lvl_e;

   function automatic drive_lvl_e row_code(input logic frame, input logic bit_r, input logic on);
      drive_lvl_e c;
      if (!on)           c = LVL_V5;
      else if (!frame)   c = bit_r ? LVL_V0 : LVL_V43;
      else               c = bit_r ? LVL_V5 : LVL_V12;
      return c;
   endfunction
endpackage

// File: rtl/row_lp_edge.sv
module row_lp_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lp,
   output logic fall
);
   logic lp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lp_q <= 1'b0;
      else        lp_q <= lp;
   end

   assign fall = lp_q & ~lp;

   AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall); // R1
endmodule

// File: rtl/row_scan_chain.sv
module row_scan_chain #(
   parameter int ROWS = 240
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            shift_en,
   input  logic            clear,
   input  logic            up,
   input  logic            dual,
   input  logic            head_in,
   input  logic            dual_in,
   output logic [ROWS-1:0] q
);
   localparam int HALF = ROWS / 2;

   logic [ROWS-1:0] nxt;

   for (genvar i = 0; i < ROWS; i++) begin : g_bit
      logic from_lo, from_hi;
      if (i == 0) begin : g_lo_end
         assign from_lo = head_in;
      end else if (i == HALF) begin : g_lo_split
         assign from_lo = dual ? dual_in : q[i-1];
      end else begin : g_lo_mid
         assign from_lo = q[i-1];
      end
      if (i == ROWS-1) begin : g_hi_end
         assign from_hi = head_in;
      end else if (i == HALF-1) begin : g_hi_split
         assign from_hi = dual ? dual_in : q[i+1];
      end else begin : g_hi_mid
         assign from_hi = q[i+1];
      end
      assign nxt[i] = up ? from_lo : from_hi;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (clear)    q <= '0;
      else if (shift_en) q <= nxt;
   end

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_en && !clear) |=> $stable(q)); // R1
   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (q == '0)); // R8
   AST_UP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !clear && up) |=> (q[0] == $past(head_in))); // R2
   AST_DN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !clear && !up) |=> (q[ROWS-1] == $past(head_in))); // R3
   AST_DUAL_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !clear && up && dual) |=> (q[HALF] == $past(dual_in))); // R4
   AST_DUAL_DN: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !clear && !up && dual) |=> (q[HALF-1] == $past(dual_in))); // R5
   AST_SINGLE_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !clear && up && !dual) |=> (q[HALF] == $past(q[HALF-1]))); // R2
endmodule

// File: rtl/row_level_enc.sv
module row_level_enc
   import row_scan_pkg::*;
#(
   parameter int ROWS = 240
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame,
   input  logic              on,
   input  logic [ROWS-1:0]   bits,
   output logic [2*ROWS-1:0] lvl
);
   for (genvar i = 0; i < ROWS; i++) begin : g_row
      drive_lvl_e c;
      assign c = row_code(frame, bits[i], on);
      assign lvl[2*i +: 2] = c;
   end

   AST_BLANK_V5: assert property (@(posedge clk) disable iff (!rst_n)
      !on |-> (lvl == {ROWS{2'd3}})); // R8
endmodule

// File: rtl/row_scan_driver.sv
module row_scan_driver #(
   parameter int ROWS = 240
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lp,
   input  logic              scan_up,
   input  logic              dual_mode,
   input  logic              disp_on,
   input  logic              frame_inv,
   input  logic              dual_in,
   input  logic              end_a_in,
   output logic              end_a_out,
   output logic              end_a_oe,
   input  logic              end_b_in,
   output logic              end_b_out,
   output logic              end_b_oe,
   output logic [2*ROWS-1:0] row_lvl
);
   if (ROWS < 4 || (ROWS % 2) != 0) begin : g_bad_rows
      $error("row_scan_driver: ROWS must be even and at least 4");
   end

   logic            lp_fall;
   logic            head_in;
   logic [ROWS-1:0] sr;

   row_lp_edge u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .lp   (lp),
      .fall (lp_fall)
   );

   assign head_in = scan_up ? end_a_in : end_b_in;

   row_scan_chain #(.ROWS(ROWS)) u_chain (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_en(lp_fall & disp_on),
      .clear   (~disp_on),
      .up      (scan_up),
      .dual    (dual_mode),
      .head_in (head_in),
      .dual_in (dual_in),
      .q       (sr)
   );

   row_level_enc #(.ROWS(ROWS)) u_enc (
      .clk  (clk),
      .rst_n(rst_n),
      .frame(frame_inv),
      .on   (disp_on),
      .bits (sr),
      .lvl  (row_lvl)
   );

   assign end_a_out = sr[0];
   assign end_b_out = sr[ROWS-1];
   assign end_a_oe  = ~scan_up;
   assign end_b_oe  = scan_up;

   AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot({end_a_oe, end_b_oe})); // R6
   AST_FAR_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      end_b_oe |-> (end_b_out == sr[ROWS-1])); // R6
endmodule

// File: tb/tb_row_scan_driver.sv
module tb_row_scan_driver;
   localparam int N = 8;
   localparam int H = N / 2;

   logic clk = 1'b0;
   logic rst_n, lp, scan_up, dual_mode, disp_on, frame_inv, dual_in, end_a_in, end_b_in;
   logic end_a_out, end_a_oe, end_b_out, end_b_oe;
   logic [2*N-1:0] row_lvl;
   logic [N-1:0] exp_sr;
   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   row_scan_driver #(.ROWS(N)) dut (
      .clk(clk), .rst_n(rst_n), .lp(lp), .scan_up(scan_up), .dual_mode(dual_mode),
      .disp_on(disp_on), .frame_inv(frame_inv), .dual_in(dual_in),
      .end_a_in(end_a_in), .end_a_out(end_a_out), .end_a_oe(end_a_oe),
      .end_b_in(end_b_in), .end_b_out(end_b_out), .end_b_oe(end_b_oe),
      .row_lvl(row_lvl)
   );

   function automatic logic [1:0] want_code(logic f, logic r, logic on);
      if (!on) return 2'd3;
      if (!f)  return r ? 2'd0 : 2'd2;
      return r ? 2'd3 : 2'd1;
   endfunction

   task automatic check(string tag);
      logic [2*N-1:0] want;
      logic [3:0] ends_got, ends_want;
      for (int i = 0; i < N; i++) want[2*i +: 2] = want_code(frame_inv, exp_sr[i], disp_on);
      n_chk++;
      if (row_lvl !== want) begin
         n_err++;
         $display("FAIL %s row_lvl actual=%h expected=%h", tag, row_lvl, want);
      end
      ends_got  = {end_a_oe, end_b_oe, end_a_out, end_b_out};
      ends_want = {~scan_up, scan_up, exp_sr[0], exp_sr[N-1]};
      n_chk++;
      if (ends_got !== ends_want) begin
         n_err++;
         $display("FAIL %s R6 ends actual=%b expected=%b", tag, ends_got, ends_want);
      end
   endtask

   task automatic model_shift(logic a, logic b, logic d);
      logic [N-1:0] o;
      o = exp_sr;
      if (!disp_on) return;
      if (scan_up) begin
         exp_sr = {o[N-2:0], a};
         if (dual_mode) exp_sr[H] = d;
      end else begin
         exp_sr = {b, o[N-1:1]};
         if (dual_mode) exp_sr[H-1] = d;
      end
   endtask

   task automatic pulse(logic a, logic b, logic d, string tag);
      @(negedge clk);
      end_a_in = a; end_b_in = b; dual_in = d;
      lp = 1'b1;
      @(negedge clk);
      check({"R1 rise ", tag});
      lp = 1'b0;
      @(negedge clk);
      model_shift(a, b, d);
      check(tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL R1 watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [N-1:0] pat;
      rst_n = 0; lp = 0; scan_up = 1; dual_mode = 0; disp_on = 1; frame_inv = 0;
      dual_in = 0; end_a_in = 0; end_b_in = 0; exp_sr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R7 reset");

      // R2 token walk upward, single chain; end_b_in and dual_in ignored (R10)
      pulse(1, 1, 1, "R2 token in");
      for (int k = 0; k < N; k++) pulse(0, 1, 1, "R2 R10 walk up");

      // R1 steady high strobe: no shift
      @(negedge clk); lp = 1; end_a_in = 1;
      repeat (4) @(negedge clk);
      check("R1 steady high");
      lp = 0; @(negedge clk); model_shift(1, 0, 0); check("R1 fall after hold");

      // R7 both frames with pattern
      pat = 8'b1011_0011;
      for (int f = 0; f < 2; f++) begin
         frame_inv = f[0];
         for (int k = 0; k < N; k++) pulse(pat[k], 0, 0, "R7 R2 pattern");
      end

      // R3 downward single; end_a_in ignored (R10)
      scan_up = 0;
      for (int k = 0; k < N; k++) pulse(~k[0], pat[k], k[1], "R3 R10 walk down");
      frame_inv = 0;
      for (int k = 0; k < N; k++) pulse(1, ~pat[k], 0, "R3 R7 walk down");

      // R4 dual upward
      scan_up = 1; dual_mode = 1;
      for (int k = 0; k < N; k++) pulse(pat[k], 1, ~pat[k], "R4 dual up");
      pulse(1, 0, 0, "R4 dual up token");
      for (int k = 0; k < H; k++) pulse(0, 1, 0, "R4 no cross up");

      // R5 dual downward
      scan_up = 0; frame_inv = 1;
      for (int k = 0; k < N; k++) pulse(0, pat[k], k[0], "R5 dual down");
      pulse(1, 1, 0, "R5 dual down token");
      for (int k = 0; k < H; k++) pulse(1, 0, 0, "R5 no cross down");

      // R8 blanking
      pulse(1, 1, 1, "R5 refill");
      @(negedge clk); disp_on = 0;
      @(negedge clk); exp_sr = '0; check("R8 blank");
      pulse(1, 1, 1, "R8 strobe ignored");
      frame_inv = 0;
      @(negedge clk); disp_on = 1;
      @(negedge clk); check("R9 deselect f0");
      frame_inv = 1;
      repeat (3) @(negedge clk);
      check("R9 deselect f1");
      scan_up = 1; dual_mode = 0;
      pulse(1, 0, 0, "R9 first data");

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule